// File: doc/BRIEF.md
# INTx Virtual-Wire Interrupt Combiner

This block lives on the root-complex side of a PCI Express port. Upstream logic decodes inbound INTx assert and negate messages. This block holds each of the four legacy interrupts (A, B, C, D) as a persistent level, the virtual wire. A wire stays set from its assert message until its negate message arrives. No timer or pulse logic is involved.

Each wire is paired with one external interrupt request pin. The pin is active-low and passes through a two-flop synchronizer. The wire and the synchronized pin are merged onto one interrupt-controller input, so both sources share that input. The merged line is active-low and level-style: it is held low for as long as either source requests service.

Message events arrive on `LANES` parallel lanes, two by default. Each lane carries a valid strobe, a 2-bit wire selector and an assert/negate flag. If one cycle brings both an assert and a negate for the same wire, the negate takes effect.

Top module: `intx_wire_merge`

## Requirements
- R1: While reset is held and after its release, every virtual wire is deasserted and synchronizer stages read inactive (1), so every `irqOutN` bit is high while the pins are high.
- R2: A lane with `msgValid` high and `msgAssert` high sets the wire selected by `msgSel`, encoded 0=A, 1=B, 2=C, 3=D, where bit n of `irqOutN` belongs to wire n. The matching `irqOutN` bit is low from the clock edge that samples the message.
- R3: A lane with `msgValid` high and `msgAssert` low clears the selected wire at the sampling edge.
- R4: Repeating an assert on a set wire, or a negate on a clear wire, leaves that wire unchanged.
- R5: A message changes only the selected wire. The other three wires keep their state.
- R6: An external pin `extReqN[n]` driven low appears on `irqOutN[n]` after exactly two clock edges, through a two-flop synchronizer. It has no effect after the first edge.
- R7: `irqOutN[n]` is low when wire n is set or the synchronized pin n is low. It is high only when neither is true.
- R8: When one cycle carries both an assert and a negate for the same wire, on any lanes, the wire ends up clear.
- R9: A lane whose `msgValid` is low has no effect, whatever its selector and flag.
- R10: A set wire keeps its output low on every cycle until a negate arrives. The output is a level, not a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msgValid | input | LANES | Per-lane message strobe |
| msgSel | input | 2*LANES | Per-lane wire selector, lane k at bits [2k+1:2k] |
| msgAssert | input | LANES | Per-lane flag: 1 assert, 0 negate |
| extReqN | input | 4 | Active-low external interrupt request pins |
| irqOutN | output | 4 | Merged active-low level interrupt lines |

## Verification
A wrong wire state shows on the matching `irqOutN` bit in the first cycle after the message edge, unless that pin is also low. The bench therefore holds pins high while it probes a wire, and it checks the state again after later messages to prove it persists. A synchronizer fault shows as an output change one edge early or late relative to a pin transition. A lost negate-wins rule shows as a line stuck low after a conflicting cycle.

// File: rtl/intx_pkg.sv
package intx_pkg;
  localparam int NUM_WIRES = 4;
  localparam int SEL_W = $clog2(NUM_WIRES);

  typedef struct packed {
    logic [NUM_WIRES-1:0] setMask;
    logic [NUM_WIRES-1:0] clrMask;
  } wireStrobes_t;
endpackage

// File: rtl/intx_ctrl.sv
module intx_ctrl
  import intx_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [LANES-1:0]       msgValid,
  input  logic [SEL_W*LANES-1:0] msgSel,
  input  logic [LANES-1:0]       msgAssert,
  output wireStrobes_t           strobes
);
  logic [NUM_WIRES-1:0] rawSet;
  logic [NUM_WIRES-1:0] rawClr;

  always_comb begin
    rawSet = '0;
    rawClr = '0;
    for (int lane = 0; lane < LANES; lane++) begin
      if (msgValid[lane]) begin
        if (msgAssert[lane])
          rawSet[msgSel[lane*SEL_W +: SEL_W]] = 1'b1;
        else
          rawClr[msgSel[lane*SEL_W +: SEL_W]] = 1'b1;
      end
    end
  end

  // negate dominates any same-cycle assert on the same wire
  assign strobes.setMask = rawSet & ~rawClr;
  assign strobes.clrMask = rawClr;

  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid == '0) |-> (strobes == '0)); // R9
endmodule

// File: rtl/intx_datapath.sv
module intx_datapath
  import intx_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  wireStrobes_t         strobes,
  input  logic [NUM_WIRES-1:0] extReqN,
  output logic [NUM_WIRES-1:0] irqOutN
);
  logic [NUM_WIRES-1:0] wireState;
  logic [NUM_WIRES-1:0] syncStage1;
  logic [NUM_WIRES-1:0] syncStage2;

  for (genvar w = 0; w < NUM_WIRES; w++) begin : g_wire
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        wireState[w]  <= 1'b0;
        syncStage1[w] <= 1'b1;
        syncStage2[w] <= 1'b1;
      end else begin
        if (strobes.clrMask[w])      wireState[w] <= 1'b0;
        else if (strobes.setMask[w]) wireState[w] <= 1'b1;
        syncStage1[w] <= extReqN[w];
        syncStage2[w] <= syncStage1[w];
      end
    end

    assign irqOutN[w] = ~(wireState[w] | ~syncStage2[w]);

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rstN)
      (strobes.setMask[w] && !strobes.clrMask[w]) |=> wireState[w]); // R2
    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
      strobes.clrMask[w] |=> !wireState[w]); // R8
    AST_WIRE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
      (!strobes.setMask[w] && !strobes.clrMask[w]) |=> $stable(wireState[w])); // R10
    AST_WIRE_DRIVES_LINE: assert property (@(posedge clk) disable iff (!rstN)
      wireState[w] |-> !irqOutN[w]); // R7
  end
endmodule

// File: rtl/intx_wire_merge.sv
module intx_wire_merge
  import intx_pkg::*;
#(
  parameter int LANES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [LANES-1:0]       msgValid,
  input  logic [2*LANES-1:0]     msgSel,
  input  logic [LANES-1:0]       msgAssert,
  input  logic [NUM_WIRES-1:0]   extReqN,
  output logic [NUM_WIRES-1:0]   irqOutN
);
  wireStrobes_t strobes;

  intx_ctrl #(.LANES(LANES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .msgValid  (msgValid),
    .msgSel    (msgSel),
    .msgAssert (msgAssert),
    .strobes   (strobes)
  );

  intx_datapath u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .extReqN (extReqN),
    .irqOutN (irqOutN)
  );
endmodule

// File: tb/tb_intx_wire_merge.sv
module tb_intx_wire_merge;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [LANES-1:0]   msgValid = '0;
  logic [2*LANES-1:0] msgSel = '0;
  logic [LANES-1:0]   msgAssert = '0;
  logic [3:0]         extReqN = 4'hF;
  logic [3:0]         irqOutN;

  int checks = 0;
  int errors = 0;
  logic [3:0] expWire = '0;
  logic [3:0] expS1 = 4'hF;
  logic [3:0] expS2 = 4'hF;

  always #(CLK_PERIOD/2) clk = ~clk;

  intx_wire_merge #(.LANES(LANES)) dut (
    .clk(clk), .rstN(rstN), .msgValid(msgValid), .msgSel(msgSel),
    .msgAssert(msgAssert), .extReqN(extReqN), .irqOutN(irqOutN)
  );

  function automatic logic [3:0] nextWires(input logic [3:0] cur,
      input logic [LANES-1:0] v, input logic [2*LANES-1:0] s, input logic [LANES-1:0] a);
    logic [3:0] setM = '0;
    logic [3:0] clrM = '0;
    for (int k = 0; k < LANES; k++) begin
      if (v[k]) begin
        if (a[k]) setM[s[2*k +: 2]] = 1'b1;
        else      clrM[s[2*k +: 2]] = 1'b1;
      end
    end
    return (cur | setM) & ~clrM;
  endfunction

  function automatic logic [3:0] expLines(input logic [3:0] w, input logic [3:0] s2);
    return ~(w | ~s2);
  endfunction

  task automatic check(input string tag, input logic [3:0] got, input logic [3:0] want);
    checks++;
    if (got !== want) begin
      errors++;
      $display("FAIL %s irqOutN=%b expected=%b", tag, got, want);
    end
  endtask

  // inputs are driven at negedge; one posedge; compare at the next negedge
  task automatic step(input string tag, input logic [LANES-1:0] v,
      input logic [2*LANES-1:0] s, input logic [LANES-1:0] a, input logic [3:0] pins);
    msgValid = v; msgSel = s; msgAssert = a; extReqN = pins;
    @(posedge clk);
    expWire = nextWires(expWire, v, s, a);
    expS2 = expS1;
    expS1 = pins;
    @(negedge clk);
    check(tag, irqOutN, expLines(expWire, expS2));
  endtask

  task automatic one(input string tag, input logic [1:0] sel, input logic asrt);
    step(tag, 2'b01, {2'b00, sel}, {1'b0, asrt}, 4'hF);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    checks++; errors++;
    $display("FAIL watchdog expired irqOutN=%b expected=finish", irqOutN);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1 during reset", irqOutN, 4'hF);
    rstN = 1'b1;
    step("R1 after release", 2'b00, '0, '0, 4'hF);

    for (int w = 0; w < 4; w++) one("R2 assert selected wire", 2'(w), 1'b1);
    check("R10 all wires held low", irqOutN, 4'h0);
    for (int w = 0; w < 4; w++) one("R3 negate selected wire", 2'(w), 1'b0);
    check("R3 all cleared", irqOutN, 4'hF);

    one("R5 assert C only", 2'd2, 1'b1);
    check("R5 only line 2 low", irqOutN, 4'b1011);
    one("R4 repeated assert", 2'd2, 1'b1);
    check("R4 assert idempotent", irqOutN, 4'b1011);
    one("R4 negate C", 2'd2, 1'b0);
    one("R4 repeated negate", 2'd2, 1'b0);
    check("R4 negate idempotent", irqOutN, 4'hF);

    for (int k = 0; k < 4; k++) step("R10 idle hold", 2'b00, '0, '0, 4'hF);
    one("R10 assert B", 2'd1, 1'b1);
    for (int k = 0; k < 5; k++) step("R10 B stays low", 2'b00, '0, '0, 4'hF);
    check("R10 B level", irqOutN, 4'b1101);
    one("R10 negate B", 2'd1, 1'b0);

    step("R9 invalid lanes ignored", 2'b00, 4'b1110, 2'b11, 4'hF);
    check("R9 no effect", irqOutN, 4'hF);

    step("R8 conflict on D", 2'b11, 4'b1111, 2'b01, 4'hF);
    check("R8 negate wins", irqOutN, 4'hF);
    one("R8 set A", 2'd0, 1'b1);
    step("R8 conflict on A", 2'b11, 4'b0000, 2'b10, 4'hF);
    check("R8 A cleared", irqOutN, 4'hF);

    step("R6 pin 1 low first edge", 2'b00, '0, '0, 4'b1101);
    check("R6 not yet visible", irqOutN, 4'hF);
    step("R6 pin 1 low second edge", 2'b00, '0, '0, 4'b1101);
    check("R6 visible after two edges", irqOutN, 4'b1101);
    one("R7 wire B plus pin", 2'd1, 1'b1);
    step("R7 pin released", 2'b00, '0, '0, 4'hF);
    step("R7 pin released 2", 2'b00, '0, '0, 4'hF);
    check("R7 wire keeps line low", irqOutN, 4'b1101);
    one("R7 negate B", 2'd1, 1'b0);
    check("R7 both gone", irqOutN, 4'hF);

    for (int k = 0; k < 400; k++) begin
      logic [LANES-1:0] v = LANES'($urandom);
      logic [2*LANES-1:0] s = (2*LANES)'($urandom);
      logic [LANES-1:0] a = LANES'($urandom);
      logic [3:0] p = (($urandom % 4) == 0) ? 4'($urandom) : 4'hF;
      step("R2 R3 R5 R7 random", v, s, a, p);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule